// File: doc/BRIEF.md
# Multi-channel down-counter timer bank

The block is a memory-mapped timer peripheral. It holds four independent down-counters and one watchdog counter behind a simple synchronous register bus. Software programs each counter's start value and reload value. It then turns the counters on through one shared control word. A channel counts either every core clock or only on cycles where the reference tick input is high; a per-channel select bit picks which. The reference tick is made outside the block.

Each general channel is a small state machine with three states. `CH_IDLE` means the channel is switched off. `CH_COUNT` means it is switched on and able to change. `CH_PARKED` means it is switched on, sitting at zero, with auto-reload off. The transitions are: *arm* (IDLE to COUNT when enabled), *disarm* (any state to IDLE when the enable bit drops), *park* (COUNT to PARKED when the count lands on zero with auto-reload off) and *rearm* (PARKED to COUNT on a value write or when auto-reload is switched on). The watchdog has three states of its own. `WD_OFF` means disabled. `WD_RUN` means counting. `WD_BARKED` means it has reached zero and is holding the reset request. Its transitions are *start* (OFF to RUN), *stop* (RUN to OFF), *bark* (RUN to BARKED on the step from one to zero) and *pet* (a value write, leaving BARKED for RUN or OFF).

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero, no counter is enabled, all expiry outputs are low and the reset request is low.
- R2: Byte addresses: control 0x00; channel n reload 0x10+8n and value 0x14+8n (n = 0..3); watchdog reload 0x30 and value 0x34. A read returns the register in the next cycle on `bus_rdata`, sampled before that edge's update.
- R3: Control bit layout: channel n enable is bit 2n, channel n auto-reload is bit 2n+1, watchdog enable is bit 8, channel n reference-clock select is bit 11+n. All other control bits read zero.
- R4: An enabled channel decreases by exactly one per selected tick. A disabled channel holds its value. Reading a value never changes it.
- R5: With its select bit clear a channel ticks every core clock. With the bit set it ticks only in cycles where `ref_tick` is high.
- R6: A value write loads the counter at that edge and takes priority over counting. A reload write changes only the stored reload value.
- R7: With auto-reload set, a channel at zero loads its reload value on the next tick. A reload of 0xFFFFFFFF gives a free-running wrap from 0 to all ones.
- R8: With auto-reload clear, a channel that reaches zero stays at zero until its value register is written.
- R9: `tmr_expire[n]` is high for exactly one cycle, the first cycle in which the channel reads zero after a tick stepped it from one.
- R10: The enabled watchdog decreases once per core clock. On stepping from one to zero it raises `wdog_rst_req`, which stays high even if the watchdog is then disabled.
- R11: Writing the watchdog value register loads it and drops `wdog_rst_req` at the same edge.
- R12: Addresses 0x04, 0x08, 0x0C, 0x38 and 0x3C read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference-clock strobe for channels with select set |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | CNT_W | Read data, valid the cycle after `bus_rd` |
| tmr_expire | output | NUM_TMR | Per-channel one-cycle expiry pulse |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench builds the block with its default parameters: four channels and 32-bit counters. At that width a channel can only reach zero from a small value written directly, so every expiry, park and watchdog bark is reached by loading small counts. The all-ones wrap is exercised through the reload path. The control-mask, reference-gating and reserved-slot cases all fall within the four-channel map.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_WORD   = 0;
    localparam int TMR_WORD0   = 4;
    localparam int WD_RL_WORD  = 12;
    localparam int WD_VAL_WORD = 13;
    localparam int WD_EN_BIT   = 8;
    localparam int CS_BIT0     = 11;
    localparam int MAX_TMR     = 4;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_COUNT  = 2'd1,
        CH_PARKED = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_RUN    = 2'd1,
        WD_BARKED = 2'd2
    } wd_state_e;

    function automatic logic [31:0] ctrl_mask(input int nt);
        logic [31:0] m;
        m = 32'h1 << WD_EN_BIT;
        for (int n = 0; n < nt; n++) begin
            m = m | (32'h3 << (2 * n)) | (32'h1 << (CS_BIT0 + n));
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_wr,
    input  logic [CNT_W-1:0]                bus_wdata,
    input  logic                            bus_rd,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]   t_reload,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]   t_value,
    input  logic [CNT_W-1:0]                wd_reload,
    input  logic [CNT_W-1:0]                wd_value,
    output logic [CNT_W-1:0]                ctrl_q,
    output logic [NUM_TMR-1:0]              rl_wr,
    output logic [NUM_TMR-1:0]              val_wr,
    output logic                            wd_rl_wr,
    output logic                            wd_val_wr,
    output logic [CNT_W-1:0]                bus_rdata
);

    localparam logic [CNT_W-1:0] MASK = CNT_W'(ctrl_mask(NUM_TMR));

    int widx;
    logic [CNT_W-1:0] rd_mux;
    logic [1:0] unused_lsb;

    assign widx       = int'(bus_addr[ADDR_W-1:2]);
    assign unused_lsb = bus_addr[1:0];

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_dec
        assign rl_wr[n]  = bus_wr && (widx == TMR_WORD0 + 2 * n);
        assign val_wr[n] = bus_wr && (widx == TMR_WORD0 + 2 * n + 1);
    end

    assign wd_rl_wr  = bus_wr && (widx == WD_RL_WORD);
    assign wd_val_wr = bus_wr && (widx == WD_VAL_WORD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && widx == CTRL_WORD) begin
            ctrl_q <= bus_wdata & MASK;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (widx == CTRL_WORD)   rd_mux = ctrl_q;
        if (widx == WD_RL_WORD)  rd_mux = wd_reload;
        if (widx == WD_VAL_WORD) rd_mux = wd_value;
        for (int n = 0; n < NUM_TMR; n++) begin
            if (widx == TMR_WORD0 + 2 * n)     rd_mux = t_reload[n];
            if (widx == TMR_WORD0 + 2 * n + 1) rd_mux = t_value[n];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             auto_rl,
    input  logic             tick,
    input  logic             rl_wr,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] value,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] val_q, val_d, rl_q;
    logic             hit, exp_q;

    always_comb begin
        val_d = val_q;
        hit   = 1'b0;
        if (val_wr) begin
            val_d = wdata;
        end else begin
            unique case (state_q)
                CH_IDLE, CH_COUNT: begin
                    if (en && tick) begin
                        if (val_q != '0) begin
                            val_d = val_q - ONE;
                            hit   = (val_q == ONE);
                        end else if (auto_rl) begin
                            val_d = rl_q;
                        end
                    end
                end
                CH_PARKED: begin
                    if (en && tick && auto_rl) val_d = rl_q;
                end
                default: ;
            endcase
        end
        if (!en)                          state_d = CH_IDLE;
        else if (val_d == '0 && !auto_rl) state_d = CH_PARKED;
        else                              state_d = CH_COUNT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            val_q   <= '0;
            rl_q    <= '0;
        end else begin
            state_q <= state_d;
            val_q   <= val_d;
            if (rl_wr) rl_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) exp_q <= 1'b0;
        else        exp_q <= hit;
    end

    assign reload = rl_q;
    assign value  = val_q;
    assign expire = exp_q;

endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rl_wr,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] value,
    output logic             rst_req
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] val_q, val_d, rl_q;
    logic             req_q;

    always_comb begin
        val_d   = val_q;
        state_d = state_q;
        if (val_wr) begin
            val_d   = wdata;
            state_d = en ? WD_RUN : WD_OFF;
        end else begin
            unique case (state_q)
                WD_OFF, WD_RUN: begin
                    if (en) begin
                        state_d = WD_RUN;
                        if (val_q != '0) begin
                            val_d = val_q - ONE;
                            if (val_q == ONE) state_d = WD_BARKED;
                        end
                    end else begin
                        state_d = WD_OFF;
                    end
                end
                WD_BARKED: ;
                default: state_d = WD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            val_q   <= '0;
            rl_q    <= '0;
        end else begin
            state_q <= state_d;
            val_q   <= val_d;
            if (rl_wr) rl_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= (state_d == WD_BARKED);
    end

    assign reload  = rl_q;
    assign value   = val_q;
    assign rst_req = req_q;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [CNT_W-1:0]   bus_wdata,
    input  logic               bus_rd,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic [NUM_TMR-1:0] tmr_expire,
    output logic               wdog_rst_req
);

    logic [CNT_W-1:0]              ctrl_q;
    logic [NUM_TMR-1:0][CNT_W-1:0] t_reload, t_value;
    logic [NUM_TMR-1:0]            rl_wr, val_wr;
    logic                          wd_rl_wr, wd_val_wr;
    logic [CNT_W-1:0]              wd_reload, wd_value;
    logic                          unused_ctrl;

    assign unused_ctrl = ^ctrl_q;

    tmr_regif #(
        .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .t_reload  (t_reload),
        .t_value   (t_value),
        .wd_reload (wd_reload),
        .wd_value  (wd_value),
        .ctrl_q    (ctrl_q),
        .rl_wr     (rl_wr),
        .val_wr    (val_wr),
        .wd_rl_wr  (wd_rl_wr),
        .wd_val_wr (wd_val_wr),
        .bus_rdata (bus_rdata)
    );

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_chan
        logic tick;
        assign tick = ctrl_q[CS_BIT0 + n] ? ref_tick : 1'b1;

        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctrl_q[2 * n]),
            .auto_rl (ctrl_q[2 * n + 1]),
            .tick    (tick),
            .rl_wr   (rl_wr[n]),
            .val_wr  (val_wr[n]),
            .wdata   (bus_wdata),
            .reload  (t_reload[n]),
            .value   (t_value[n]),
            .expire  (tmr_expire[n])
        );
    end

    tmr_wdog #(.CNT_W(CNT_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q[WD_EN_BIT]),
        .rl_wr   (wd_rl_wr),
        .val_wr  (wd_val_wr),
        .wdata   (bus_wdata),
        .reload  (wd_reload),
        .value   (wd_value),
        .rst_req (wdog_rst_req)
    );

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ref_tick,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_wr,
    input logic                          bus_rd,
    input logic [CNT_W-1:0]              bus_rdata,
    input logic [NUM_TMR-1:0]            tmr_expire,
    input logic                          wdog_rst_req,
    input logic [CNT_W-1:0]              ctrl_q,
    input logic [NUM_TMR-1:0][CNT_W-1:0] t_value
);

    int   widx;
    logic rsv, wd_pet;

    assign widx   = int'(bus_addr[ADDR_W-1:2]);
    assign rsv    = !((widx == CTRL_WORD) || (widx == WD_RL_WORD) || (widx == WD_VAL_WORD) ||
                      (widx >= TMR_WORD0 && widx < TMR_WORD0 + 2 * NUM_TMR));
    assign wd_pet = bus_wr && (widx == WD_VAL_WORD);

    p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rsv) |=> (bus_rdata == '0));

    p_wdog_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_rst_req && !wd_pet) |=> wdog_rst_req);

    p_wdog_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pet |=> !wdog_rst_req);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        logic vwr;
        assign vwr = bus_wr && (widx == TMR_WORD0 + 2 * i + 1);

        p_hold_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_q[2 * i] && !vwr) |=> $stable(t_value[i]));

        p_step_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[2 * i] && !ctrl_q[CS_BIT0 + i] && !vwr && t_value[i] != '0)
            |=> (t_value[i] == $past(t_value[i]) - CNT_W'(1)));

        p_ref_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[CS_BIT0 + i] && !ref_tick && !vwr) |=> $stable(t_value[i]));

        p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[2 * i] && !ctrl_q[2 * i + 1] && t_value[i] == '0 && !vwr)
            |=> (t_value[i] == '0));

        p_expire_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_expire[i] |-> (t_value[i] == '0));

        p_expire_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_expire[i] |=> !tmr_expire[i]);
    end

endmodule

bind tmr_bank tmr_bank_chk #(
    .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .tmr_expire   (tmr_expire),
    .wdog_rst_req (wdog_rst_req),
    .ctrl_q       (ctrl_q),
    .t_value      (t_value)
);

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  tmr_expire;
    logic        wdog_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tmr_expire(tmr_expire), .wdog_rst_req(wdog_rst_req)
    );

    // behavioural reference model
    logic [31:0] m_ctrl, m_wrl, m_wval, m_rdata;
    logic [31:0] m_rl  [4];
    logic [31:0] m_val [4];
    logic [3:0]  m_exp;
    logic        m_wreq;

    function automatic logic [31:0] m_read(input int w);
        if (w == 0)  return m_ctrl;
        if (w == 12) return m_wrl;
        if (w == 13) return m_wval;
        if (w >= 4 && w < 12) return (w % 2 == 0) ? m_rl[(w - 4) / 2] : m_val[(w - 5) / 2];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        int w;
        w = int'(bus_addr[5:2]);
        if (!rst_n) begin
            m_ctrl = 0; m_wrl = 0; m_wval = 0; m_rdata = 0; m_exp = 0; m_wreq = 0;
            for (int n = 0; n < 4; n++) begin m_rl[n] = 0; m_val[n] = 0; end
        end else begin
            if (bus_rd) m_rdata = m_read(w);
            for (int n = 0; n < 4; n++) begin
                logic tk;
                logic [31:0] nv;
                tk = m_ctrl[11 + n] ? ref_tick : 1'b1;
                nv = m_val[n];
                m_exp[n] = 1'b0;
                if (bus_wr && w == 5 + 2 * n) nv = bus_wdata;
                else if (m_ctrl[2 * n] && tk) begin
                    if (m_val[n] != 0) begin nv = m_val[n] - 1; m_exp[n] = (m_val[n] == 1); end
                    else if (m_ctrl[2 * n + 1]) nv = m_rl[n];
                end
                m_val[n] = nv;
                if (bus_wr && w == 4 + 2 * n) m_rl[n] = bus_wdata;
            end
            if (bus_wr && w == 13) begin m_wval = bus_wdata; m_wreq = 0; end
            else if (m_ctrl[8] && !m_wreq && m_wval != 0) begin
                if (m_wval == 1) m_wreq = 1;
                m_wval = m_wval - 1;
            end
            if (bus_wr && w == 12) m_wrl = bus_wdata;
            if (bus_wr && w == 0)  m_ctrl = bus_wdata & 32'h0000_79FF;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 expiry vector", {28'h0, tmr_expire}, {28'h0, m_exp});
            chk("R10 watchdog request", {31'h0, wdog_rst_req}, {31'h0, m_wreq});
            chk("R4 read data", bus_rdata, m_rdata);
        end
    end

    task automatic bwr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int pulses;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 / R12: everything reads zero after reset
        chk("R1 expire after reset", {28'h0, tmr_expire}, 32'h0);
        chk("R1 request after reset", {31'h0, wdog_rst_req}, 32'h0);
        for (int w = 0; w < 16; w++) begin
            brd(6'(w * 4), v);
            chk("R1 register reset value", v, 32'h0);
        end

        // R2 / R4: channel 0 counts core clocks
        bwr(6'h14, 32'd10);
        bwr(6'h00, 32'h1);
        brd(6'h14, v);  chk("R4 first read", v, 32'd10);
        brd(6'h14, v2); chk("R4 one step per clock", v2, 32'd9);

        // R4: disabled channel holds
        bwr(6'h00, 32'h0);
        brd(6'h14, v); brd(6'h14, v2);
        chk("R4 disabled holds", v2, v);

        // R5: reference-clock select
        bwr(6'h00, 32'h0000_0801);
        bwr(6'h14, 32'd5);
        repeat (3) @(negedge clk);
        brd(6'h14, v); chk("R5 no ref tick no count", v, 32'd5);
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0; @(negedge clk);
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        brd(6'h14, v); chk("R5 two ref ticks", v, 32'd3);

        // R8 / R9: one-shot on channel 1
        bwr(6'h00, 32'h0);
        bwr(6'h1C, 32'd3);
        bwr(6'h00, 32'h4);
        pulses = 0;
        repeat (10) begin @(negedge clk); if (tmr_expire[1]) pulses++; end
        chk("R9 single pulse one-shot", pulses, 32'd1);
        brd(6'h1C, v); chk("R8 parked at zero", v, 32'd0);

        // R7 / R9: auto-reload on channel 2, period reload+1
        bwr(6'h00, 32'h0);
        bwr(6'h20, 32'd2);
        bwr(6'h24, 32'd1);
        bwr(6'h00, 32'h30);
        pulses = 0;
        repeat (12) begin @(negedge clk); if (tmr_expire[2]) pulses++; end
        chk("R7 auto-reload pulse count", pulses, 32'd4);

        // R7 / R6: all-ones wrap on channel 3, reload write leaves value alone
        bwr(6'h00, 32'h0);
        bwr(6'h28, 32'hFFFF_FFFF);
        bwr(6'h2C, 32'h0);
        bwr(6'h00, 32'hC0);
        brd(6'h2C, v);  chk("R7 value at zero", v, 32'h0);
        brd(6'h2C, v2); chk("R7 wrap to all ones", v2, 32'hFFFF_FFFF);
        bwr(6'h28, 32'h1234);
        brd(6'h28, v);  chk("R6 reload write stored", v, 32'h1234);
        brd(6'h2C, v);  chk("R6 reload write leaves value", v, 32'hFFFF_FFFC);

        // R3: control mask
        bwr(6'h00, 32'hFFFF_FFFF);
        brd(6'h00, v); chk("R3 control bit layout", v, 32'h0000_79FF);
        bwr(6'h00, 32'h0);

        // R12: reserved slots
        bwr(6'h04, 32'hDEAD_BEEF);
        brd(6'h04, v); chk("R12 reserved 0x04", v, 32'h0);
        bwr(6'h3C, 32'hCAFE_F00D);
        brd(6'h3C, v); chk("R12 reserved 0x3C", v, 32'h0);
        brd(6'h38, v); chk("R12 reserved 0x38", v, 32'h0);
        brd(6'h00, v); chk("R12 control untouched", v, 32'h0);

        // R10 / R11: watchdog
        bwr(6'h30, 32'h0ABC);
        brd(6'h30, v); chk("R2 watchdog reload", v, 32'h0ABC);
        bwr(6'h34, 32'd4);
        bwr(6'h00, 32'h100);
        repeat (6) @(negedge clk);
        chk("R10 bark at zero", {31'h0, wdog_rst_req}, 32'h1);
        bwr(6'h00, 32'h0);
        repeat (3) @(negedge clk);
        chk("R10 request sticky", {31'h0, wdog_rst_req}, 32'h1);
        bwr(6'h34, 32'h100);
        chk("R11 pet clears request", {31'h0, wdog_rst_req}, 32'h0);
        brd(6'h34, v); chk("R11 pet loads value", v, 32'h100);

        // R6: value write wins over counting
        bwr(6'h00, 32'h1);
        repeat (2) @(negedge clk);
        bwr(6'h14, 32'h50);
        brd(6'h14, v); chk("R6 value write priority", v, 32'h50);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule